// File: doc/BRIEF.md
# Dual Rotating-Frame Sequence Separator

This block splits a three-phase grid voltage, given as a fixed-point alpha-beta pair, into its positive-sequence and negative-sequence parts. Each part is expressed as a d/q pair. The block needs an angle estimate from an external angle tracker, supplied as a sine and cosine pair. It projects the voltage vector into two synchronous frames that turn in opposite directions, one at +θ and one at −θ.

A negative sequence shows up as a ripple at twice the grid frequency in the forward frame, and a positive sequence does the same in the reverse frame. The block removes that ripple by cross-feedback. Each frame subtracts the low-pass-filtered d/q values of the opposite frame, rotated by 2θ. The filters are first-order IIR stages with their cutoff near ω/√2, and each one is fed from the decoupled output of its own axis. The positive d/q pair is meant to drive an external synchronous-frame angle tracker. The negative pair can be used for separate control of negative-sequence current.

A sample is accepted on any clock where `in_valid` is high. Its four results appear two clocks later, together with a one-cycle `out_valid` strobe. The results then hold until the next strobe.

Top module: `dsx_seq_extract`

## Requirements
- R1: While reset is asserted and after its release, all four outputs read 0, `out_valid` is 0, and the four filter states are 0.
- R2: The forward-frame raw pair is `d = floor((vα·cos + vβ·sin) / 2^(TW-1))` and `q = floor((vβ·cos − vα·sin) / 2^(TW-1))`. The trig inputs are signed with TW−1 fraction bits. Right after reset these appear unchanged on `pos_d`/`pos_q`.
- R3: The reverse-frame raw pair is `d = floor((vα·cos − vβ·sin) / 2^(TW-1))` and `q = floor((vα·sin + vβ·cos) / 2^(TW-1))`. Right after reset these appear on `neg_d`/`neg_q`.
- R4: With `c2 = floor((cos²−sin²)/2^(TW-1))` and `s2 = floor(2·sin·cos/2^(TW-1))`, and with Fx being the filter state of axis x, the decoupled outputs are:
  - pos_d = rawPd − floor((Fnd·c2 + Fnq·s2)/2^(TW-1))
  - pos_q = rawPq − floor((Fnq·c2 − Fnd·s2)/2^(TW-1))
  - neg_d = rawNd − floor((Fpd·c2 − Fpq·s2)/2^(TW-1))
  - neg_q = rawNq − floor((Fpq·c2 + Fpd·s2)/2^(TW-1))
- R5: On each accepted sample, every filter state F moves to `F + floor((y − F)·K / 2^AQ)`, where y is that axis's decoupled output. K = floor(2^AQ · 6283 · CUTOFF_HZ / (1000 · SAMPLE_HZ)), which is 1441 at the defaults. The next sample uses the updated state.
- R6: Each decoupled result is clamped to the signed OW-bit range: 32767 / −32768 at the defaults.
- R7: A sample taken on clock edge k gives its results and a one-cycle `out_valid` pulse after edge k+2. Samples on consecutive clocks give consecutive pulses in the same order.
- R8: Clocks without `in_valid` change neither the outputs nor the filter states. A later sample gives the same result it would give with no gap before it.
- R9: For a balanced positive-sequence input of amplitude V that tracks the supplied angle, `neg_d`/`neg_q` settle within 256 of 0, `pos_d` settles within 256 of V, and `pos_q` settles within 256 of 0.
- R10: For a positive sequence of amplitude V1 plus a negative sequence of amplitude V2, `pos_d` settles within 256 of V1 and `neg_d` settles within 256 of V2. Both q outputs settle within 256 of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the sample on this clock |
| v_alpha | input | DW (16) | Alpha voltage, signed |
| v_beta | input | DW (16) | Beta voltage, signed |
| sin_th | input | TW (16) | sin θ, signed, TW−1 fraction bits |
| cos_th | input | TW (16) | cos θ, signed, TW−1 fraction bits |
| out_valid | output | 1 | One-cycle strobe marking new results |
| pos_d | output | OW (16) | Decoupled forward-frame d |
| pos_q | output | OW (16) | Decoupled forward-frame q |
| neg_d | output | OW (16) | Decoupled reverse-frame d |
| neg_q | output | OW (16) | Decoupled reverse-frame q |

## Verification
The assertions assume that `in_valid` stays low while reset is held, so that the strobe latency properties start from a known pipeline. The filter-bound property assumes only that the stored state and the new sample are integers of the output width, so it holds for any trig pair, even one far from unit length.

The stimulus takes sin/cos from rounded real trigonometry, so the pair stays within one LSB of unit magnitude. Amplitudes stay inside the input range, except in the deliberate saturation cases. Every sample is compared bit for bit against an arithmetic restatement of the requirements. The two steady-state runs add a tolerance check after convergence.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

  // Index of each axis in the four-lane arrays
  typedef enum int {AX_PD = 0, AX_PQ = 1, AX_ND = 2, AX_NQ = 3} axis_e;

  // Two-term dot product, floored by an arithmetic shift
  function automatic longint fx_dot(longint a, longint ka, longint b, longint kb, int fr);
    return (a * ka + b * kb) >>> fr;
  endfunction

  // Cross-coupling term: x*c2 + sgn*y*s2, floored
  function automatic longint fx_xterm(longint x, longint y, longint c2, longint s2,
                                      longint sgn, int fr);
    return (x * c2 + sgn * y * s2) >>> fr;
  endfunction

  // Clamp to a signed w-bit range
  function automatic longint fx_sat(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // One first-order IIR step
  function automatic longint fx_lpf(longint f, longint x, longint k, int q);
    return f + (((x - f) * k) >>> q);
  endfunction

endpackage

// File: rtl/dsx_proj.sv
module dsx_proj
  import dsx_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   v_alpha,
  input  logic signed [DW-1:0]   v_beta,
  input  logic signed [TW-1:0]   sin_th,
  input  logic signed [TW-1:0]   cos_th,
  output logic                   st_valid,
  output logic signed [DW+1:0]   raw_pd,
  output logic signed [DW+1:0]   raw_pq,
  output logic signed [DW+1:0]   raw_nd,
  output logic signed [DW+1:0]   raw_nq,
  output logic signed [TW+1:0]   dbl_c,
  output logic signed [TW+1:0]   dbl_s
);
  localparam int RW = DW + 2;
  localparam int AW = TW + 2;
  localparam int FR = TW - 1;

  longint a, b, s, c;
  always_comb begin
    a = longint'(v_alpha);
    b = longint'(v_beta);
    s = longint'(sin_th);
    c = longint'(cos_th);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      raw_pd   <= '0;
      raw_pq   <= '0;
      raw_nd   <= '0;
      raw_nq   <= '0;
      dbl_c    <= '0;
      dbl_s    <= '0;
    end else begin
      st_valid <= in_valid;
      if (in_valid) begin
        raw_pd <= RW'(fx_dot(a, c, b, s, FR));
        raw_pq <= RW'(fx_dot(b, c, -a, s, FR));
        raw_nd <= RW'(fx_dot(a, c, -b, s, FR));
        raw_nq <= RW'(fx_dot(a, s, b, c, FR));
        dbl_c  <= AW'(fx_dot(c, c, -s, s, FR));
        dbl_s  <= AW'(fx_dot(s, c, s, c, FR));
      end
    end
  end

  // R8: projection stage keeps its contents when no sample arrives
  p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({raw_pd, raw_pq, raw_nd, raw_nq, dbl_c, dbl_s}));

endmodule

// File: rtl/dsx_lpf.sv
module dsx_lpf
  import dsx_pkg::*;
#(
  parameter int     OW   = 16,
  parameter int     AQ   = 16,
  parameter longint COEF = 1441
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [OW-1:0] x,
  output logic signed [OW-1:0] y
);
  always_ff @(posedge clk) begin
    if (!rst_n)  y <= '0;
    else if (en) y <= OW'(fx_lpf(longint'(y), longint'(x), COEF, AQ));
  end

  // R5: a step never leaves the interval between old state and new sample
  p_lpf_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((y >= $past(y) && y <= $past(x)) || (y <= $past(y) && y >= $past(x))));

  // R8: state frozen on idle clocks
  p_lpf_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y));

endmodule

// File: rtl/dsx_decouple.sv
module dsx_decouple
  import dsx_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int OW = 16
) (
  input  logic signed [DW+1:0] raw_pd,
  input  logic signed [DW+1:0] raw_pq,
  input  logic signed [DW+1:0] raw_nd,
  input  logic signed [DW+1:0] raw_nq,
  input  logic signed [TW+1:0] dbl_c,
  input  logic signed [TW+1:0] dbl_s,
  input  logic signed [OW-1:0] f_pd,
  input  logic signed [OW-1:0] f_pq,
  input  logic signed [OW-1:0] f_nd,
  input  logic signed [OW-1:0] f_nq,
  output logic signed [OW-1:0] dec_pd,
  output logic signed [OW-1:0] dec_pq,
  output logic signed [OW-1:0] dec_nd,
  output logic signed [OW-1:0] dec_nq
);
  localparam int FR = TW - 1;

  longint c2, s2;
  always_comb begin
    c2 = longint'(dbl_c);
    s2 = longint'(dbl_s);
    // each frame loses the 2θ image of the other frame's filtered vector
    dec_pd = OW'(fx_sat(longint'(raw_pd) -
             fx_xterm(longint'(f_nd), longint'(f_nq), c2, s2,  1, FR), OW));
    dec_pq = OW'(fx_sat(longint'(raw_pq) -
             fx_xterm(longint'(f_nq), longint'(f_nd), c2, s2, -1, FR), OW));
    dec_nd = OW'(fx_sat(longint'(raw_nd) -
             fx_xterm(longint'(f_pd), longint'(f_pq), c2, s2, -1, FR), OW));
    dec_nq = OW'(fx_sat(longint'(raw_nq) -
             fx_xterm(longint'(f_pq), longint'(f_pd), c2, s2,  1, FR), OW));
  end

endmodule

// File: rtl/dsx_seq_extract.sv
module dsx_seq_extract
  import dsx_pkg::*;
#(
  parameter int     DW        = 16,
  parameter int     TW        = 16,
  parameter int     OW        = 16,
  parameter int     AQ        = 16,
  parameter longint SAMPLE_HZ = 10000,
  parameter longint CUTOFF_HZ = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] v_alpha,
  input  logic signed [DW-1:0] v_beta,
  input  logic signed [TW-1:0] sin_th,
  input  logic signed [TW-1:0] cos_th,
  output logic                 out_valid,
  output logic signed [OW-1:0] pos_d,
  output logic signed [OW-1:0] pos_q,
  output logic signed [OW-1:0] neg_d,
  output logic signed [OW-1:0] neg_q
);
  // 2π taken as 6.283; coefficient scaled by 2^AQ
  localparam longint COEF = ((longint'(1) <<< AQ) * 6283 * CUTOFF_HZ) / (1000 * SAMPLE_HZ);

  logic                 st_valid;
  logic signed [DW+1:0] raw_pd, raw_pq, raw_nd, raw_nq;
  logic signed [TW+1:0] dbl_c, dbl_s;
  logic signed [OW-1:0] dec  [4];
  logic signed [OW-1:0] filt [4];

  dsx_proj #(.DW(DW), .TW(TW)) u_proj (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .v_alpha(v_alpha), .v_beta(v_beta), .sin_th(sin_th), .cos_th(cos_th),
    .st_valid(st_valid),
    .raw_pd(raw_pd), .raw_pq(raw_pq), .raw_nd(raw_nd), .raw_nq(raw_nq),
    .dbl_c(dbl_c), .dbl_s(dbl_s)
  );

  dsx_decouple #(.DW(DW), .TW(TW), .OW(OW)) u_dec (
    .raw_pd(raw_pd), .raw_pq(raw_pq), .raw_nd(raw_nd), .raw_nq(raw_nq),
    .dbl_c(dbl_c), .dbl_s(dbl_s),
    .f_pd(filt[AX_PD]), .f_pq(filt[AX_PQ]), .f_nd(filt[AX_ND]), .f_nq(filt[AX_NQ]),
    .dec_pd(dec[AX_PD]), .dec_pq(dec[AX_PQ]), .dec_nd(dec[AX_ND]), .dec_nq(dec[AX_NQ])
  );

  for (genvar i = 0; i < 4; i++) begin : g_lpf
    dsx_lpf #(.OW(OW), .AQ(AQ), .COEF(COEF)) u_lpf (
      .clk(clk), .rst_n(rst_n), .en(st_valid), .x(dec[i]), .y(filt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pos_d     <= '0;
      pos_q     <= '0;
      neg_d     <= '0;
      neg_q     <= '0;
    end else begin
      out_valid <= st_valid;
      if (st_valid) begin
        pos_d <= dec[AX_PD];
        pos_q <= dec[AX_PQ];
        neg_d <= dec[AX_ND];
        neg_q <= dec[AX_NQ];
      end
    end
  end

  // R7: each accepted sample yields a strobe two clocks later
  p_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R7: no strobe without a sample two clocks earlier
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R8: outputs hold across idle clocks
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> $stable({pos_d, pos_q, neg_d, neg_q}));

endmodule

// File: tb/sim_dsx_seq_extract.sv
module sim_dsx_seq_extract;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam int OW = 16;
  localparam int FR = 15;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n, in_valid;
  logic signed [DW-1:0] v_alpha, v_beta;
  logic signed [TW-1:0] sin_th, cos_th;
  logic out_valid;
  logic signed [OW-1:0] pos_d, pos_q, neg_d, neg_q;

  dsx_seq_extract u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .v_alpha(v_alpha), .v_beta(v_beta), .sin_th(sin_th), .cos_th(cos_th),
    .out_valid(out_valid), .pos_d(pos_d), .pos_q(pos_q), .neg_d(neg_d), .neg_q(neg_q)
  );

  int n_cmp = 0;
  int n_bad = 0;
  longint mf [4];
  longint kcoef;
  longint seed = 7;

  function automatic longint fdiv(longint n, int sh);
    longint d;
    d = longint'(1) << sh;
    if (n >= 0) return n / d;
    return -((-n + d - 1) / d);
  endfunction

  function automatic longint clampv(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint q15(real x);
    real r;
    r = x * 32767.0;
    return longint'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
  endfunction

  function automatic longint lcg_val();
    seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
    return (seed % 32001) - 16000;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_near(string tag, longint got, longint exp, longint tol);
    n_cmp++;
    if (got > exp + tol || got < exp - tol) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d (+/-%0d)", tag, got, exp, tol);
    end
  endtask

  // bench restatement of the arithmetic in R2..R6
  task automatic model(input longint a, b, s, c, output longint e [4]);
    longint pd, pq, nd, nq, c2, s2;
    pd = fdiv(a * c + b * s, FR);
    pq = fdiv(b * c - a * s, FR);
    nd = fdiv(a * c - b * s, FR);
    nq = fdiv(a * s + b * c, FR);
    c2 = fdiv(c * c - s * s, FR);
    s2 = fdiv(2 * s * c, FR);
    e[0] = clampv(pd - fdiv(mf[2] * c2 + mf[3] * s2, FR));
    e[1] = clampv(pq - fdiv(mf[3] * c2 - mf[2] * s2, FR));
    e[2] = clampv(nd - fdiv(mf[0] * c2 - mf[1] * s2, FR));
    e[3] = clampv(nq - fdiv(mf[1] * c2 + mf[0] * s2, FR));
    for (int i = 0; i < 4; i++) mf[i] = mf[i] + fdiv((e[i] - mf[i]) * kcoef, 16);
  endtask

  task automatic drive(longint a, b, s, c);
    v_alpha = DW'(a);
    v_beta  = DW'(b);
    sin_th  = TW'(s);
    cos_th  = TW'(c);
    in_valid = 1'b1;
  endtask

  task automatic cmp_out(string tag, longint e [4]);
    chk({tag, " out_valid"}, longint'(out_valid), 1);
    chk({tag, " pos_d"}, longint'(pos_d), e[0]);
    chk({tag, " pos_q"}, longint'(pos_q), e[1]);
    chk({tag, " neg_d"}, longint'(neg_d), e[2]);
    chk({tag, " neg_q"}, longint'(neg_q), e[3]);
  endtask

  // one sample, one idle clock, compare after the second edge
  task automatic send(string tag, longint a, b, s, c);
    longint e [4];
    @(negedge clk);
    drive(a, b, s, c);
    model(a, b, s, c, e);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R7 early strobe"}, longint'(out_valid), 0);
    @(negedge clk);
    cmp_out(tag, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    v_alpha = '0; v_beta = '0; sin_th = '0; cos_th = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) mf[i] = 0;
    @(negedge clk);
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 pos_d", longint'(pos_d), 0);
    chk("R1 pos_q", longint'(pos_q), 0);
    chk("R1 neg_d", longint'(neg_d), 0);
    chk("R1 neg_q", longint'(neg_q), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint e1 [4];
    longint e2 [4];
    kcoef = longint'($rtoi($floor(65536.0 * 6.283 * 35.0 / 10000.0)));
    rst_n = 1'b0;
    in_valid = 1'b0;

    // R1 then R2/R3: filters empty, outputs equal raw projections
    do_reset();
    send("R2 R3 first", 1234, -5678, q15($sin(TWO_PI / 12.0)), q15($cos(TWO_PI / 12.0)));
    send("R2 R3 second angle", -20000, 7000, q15($sin(2.0)), q15($cos(2.0)));

    // R6: saturation high and low
    do_reset();
    send("R6 high", 32767, 32767, 23170, 23170);
    chk("R6 pos_d clamp", longint'(pos_d), 32767);
    chk("R6 neg_q clamp", longint'(neg_q), 32767);
    do_reset();
    send("R6 low", -32768, -32768, 23170, 23170);
    chk("R6 pos_d clamp low", longint'(pos_d), -32768);

    // R4/R5: sweep of angles and amplitudes through the decoupling and filters
    do_reset();
    for (int k = 0; k < 240; k++) begin
      real th;
      longint a, b;
      th = TWO_PI * real'((k * 17) % 360) / 360.0;
      a = lcg_val();
      b = lcg_val();
      send("R4 R5 sweep", a, b, q15($sin(th)), q15($cos(th)));
    end

    // R7: two samples on consecutive clocks
    @(negedge clk);
    drive(9000, -3000, q15($sin(0.7)), q15($cos(0.7)));
    model(9000, -3000, q15($sin(0.7)), q15($cos(0.7)), e1);
    @(negedge clk);
    drive(-4000, 11000, q15($sin(2.9)), q15($cos(2.9)));
    model(-4000, 11000, q15($sin(2.9)), q15($cos(2.9)), e2);
    chk("R7 no strobe after one edge", longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    cmp_out("R7 first of pair", e1);
    @(negedge clk);
    cmp_out("R7 second of pair", e2);
    @(negedge clk);
    chk("R7 strobe ends", longint'(out_valid), 0);

    // R8: idle gap holds outputs and filter state
    for (int g = 0; g < 5; g++) begin
      @(negedge clk);
      chk("R8 idle strobe", longint'(out_valid), 0);
      chk("R8 idle pos_d", longint'(pos_d), e2[0]);
      chk("R8 idle neg_q", longint'(neg_q), e2[3]);
    end
    send("R8 after gap", 15000, 2500, q15($sin(4.0)), q15($cos(4.0)));

    // R9: balanced positive sequence, locked angle
    do_reset();
    for (int k = 0; k < 2400; k++) begin
      real th;
      th = TWO_PI * 50.0 * real'(k) / 10000.0;
      send("R9 R4 exact", q15(12000.0 / 32767.0 * $cos(th)), q15(12000.0 / 32767.0 * $sin(th)),
           q15($sin(th)), q15($cos(th)));
    end
    chk_near("R9 pos_d", longint'(pos_d), 12000, 256);
    chk_near("R9 pos_q", longint'(pos_q), 0, 256);
    chk_near("R9 neg_d", longint'(neg_d), 0, 256);
    chk_near("R9 neg_q", longint'(neg_q), 0, 256);

    // R10: positive 9000 plus negative 3000
    do_reset();
    for (int k = 0; k < 2400; k++) begin
      real th;
      real va, vb;
      th = TWO_PI * 50.0 * real'(k) / 10000.0;
      va = 9000.0 * $cos(th) + 3000.0 * $cos(th);
      vb = 9000.0 * $sin(th) - 3000.0 * $sin(th);
      send("R10 R4 exact", q15(va / 32767.0), q15(vb / 32767.0), q15($sin(th)), q15($cos(th)));
    end
    chk_near("R10 pos_d", longint'(pos_d), 9000, 256);
    chk_near("R10 pos_q", longint'(pos_q), 0, 256);
    chk_near("R10 neg_d", longint'(neg_d), 3000, 256);
    chk_near("R10 neg_q", longint'(neg_q), 0, 256);

    finish_run();
  end

endmodule